// File: doc/BRIEF.md
# Fractional-Divisor Serial Transceiver with Ninth-Bit Tagging

This block is an asynchronous serial transmitter and receiver pair that shares one bit-rate setting. The bit period comes from an integer part plus a fraction in eighths of a clock. A small accumulator carries the leftover fraction from one bit to the next, so the line rate does not have to divide the clock evenly. For example, 10.125 clocks per bit gives 4 Mbit/s from a 40.5 MHz clock. At 48 MHz the same logic gives 4 Mbit/s with a whole divisor of 12, or 2 Mbit/s with 24.

A mode input picks 8 or 9 data bits per frame. With nine bits, the extra bit tags each character: a one marks payload data and a zero marks a control code. The link therefore needs no escape characters. The transmitter takes characters over a valid/ready handshake. The receiver gives a one-cycle valid pulse with the byte and the tag bit, or a one-cycle framing-error pulse when the frame is bad.

Top module: `frac_uart`

## Requirements
- R1: Out of reset the serial output is high, `tx_ready` is high, and neither `rx_valid` nor `rx_frame_err` is asserted.
- R2: A character is taken in the cycle where `tx_valid` and `tx_ready` are both high. In the next cycle `tx_ready` is low and the serial output is low, which is the start bit.
- R3: A transmitted frame is a low start bit, then the data bits least significant bit first, then a high stop bit. In 8-bit mode (`cfg_nine`=0) there are 8 data bits and `tx_bit9` has no effect on the line.
- R4: In 9-bit mode (`cfg_nine`=1) a ninth data bit, equal to `tx_bit9`, follows data bit 7, so the frame is 11 bit times long. A one in this bit marks payload and a zero marks a control code.
- R5: Let D be `cfg_div_int` (at least 4) and F be `cfg_div_frac` (eighths). Bit n of a frame ends exactly n*D + floor(n*F/8) cycles after the start bit begins.
- R6: The receiver samples each bit near its midpoint, using the same divisor, after a two-flop synchroniser. A good frame gives `rx_valid` for exactly one cycle, with the byte on `rx_byte`.
- R7: `rx_bit9` carries the received ninth bit in 9-bit mode and is 0 in 8-bit mode.
- R8: A frame whose stop bit reads low gives a one-cycle `rx_frame_err` pulse and no `rx_valid`.
- R9: A low pulse on the serial input that is shorter than half a bit period produces neither `rx_valid` nor `rx_frame_err`.
- R10: `tx_ready` goes high again exactly when the stop bit ends, that is 10 bit times (8-bit mode) or 11 bit times (9-bit mode) after the start bit begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div_int | input | DIV_W (8) | Integer clocks per bit |
| cfg_div_frac | input | FRAC_W (3) | Fractional clocks per bit, in eighths |
| cfg_nine | input | 1 | 1 selects 9 data bits per frame |
| tx_valid | input | 1 | Character offered for transmit |
| tx_ready | output | 1 | Transmitter can take a character |
| tx_byte | input | 8 | Transmit data byte |
| tx_bit9 | input | 1 | Transmit ninth bit (payload tag) |
| tx_line | output | 1 | Serial output, idles high |
| rx_line | input | 1 | Serial input, asynchronous |
| rx_valid | output | 1 | One-cycle pulse when a character is received |
| rx_byte | output | 8 | Received data byte |
| rx_bit9 | output | 1 | Received ninth bit |
| rx_frame_err | output | 1 | One-cycle pulse when the stop bit reads low |

## Verification
If the fractional accumulator is wrong, the error grows with each bit. The bench compares the serial output with the R5 boundary formula on every cycle of a frame, so a fault shows as early as the first bit whose boundary should have received an extra cycle. It also shows in the cycle where `tx_ready` returns. A shifted or miscounted data register changes the word read at the bit midpoints within the same frame. A fault in the receiver's state shows within one frame: a missing valid pulse, a spurious framing error, a wrong byte, or a wrong ninth bit. The bench also sends a short glitch. If a corrupted start check accepts it, an output pulse appears within about one frame time.

// File: rtl/frac_uart_pkg.sv
package frac_uart_pkg;

   localparam int BYTE_W = 8;
   localparam int CNT_W  = 4;

   typedef enum logic [1:0] {
      TX_IDLE  = 2'd0,
      TX_START = 2'd1,
      TX_DATA  = 2'd2,
      TX_STOP  = 2'd3
   } tx_state_e;

   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_DATA  = 2'd2,
      RX_STOP  = 2'd3
   } rx_state_e;

   function automatic logic [CNT_W-1:0] data_bits(input logic nine);
      return nine ? CNT_W'(9) : CNT_W'(8);
   endfunction

endpackage

// File: rtl/frac_bit_timer.sv
module frac_bit_timer #(
   parameter int DIV_W  = 8,
   parameter int FRAC_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              load,
   input  logic              half,
   input  logic [DIV_W-1:0]  div_int,
   input  logic [FRAC_W-1:0] div_frac,
   output logic              tick
);

   logic [DIV_W-1:0]  cnt_q;
   logic [FRAC_W-1:0] acc_q;
   logic [FRAC_W:0]   acc_sum;
   logic [DIV_W-1:0]  carry_ext;

   assign acc_sum   = {1'b0, acc_q} + {1'b0, div_frac};
   assign carry_ext = {{(DIV_W-1){1'b0}}, acc_sum[FRAC_W]};
   assign tick      = run && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         acc_q <= '0;
      end else if (load) begin
         if (half) begin
            cnt_q <= (div_int >> 1) - DIV_W'(1);
            acc_q <= '0;
         end else begin
            cnt_q <= div_int - DIV_W'(1);
            acc_q <= div_frac;
         end
      end else if (tick) begin
         cnt_q <= div_int - DIV_W'(1) + carry_ext;
         acc_q <= acc_sum[FRAC_W-1:0];
      end else if (run) begin
         cnt_q <= cnt_q - DIV_W'(1);
      end
   end

endmodule

// File: rtl/frac_uart_tx.sv
module frac_uart_tx
   import frac_uart_pkg::*;
#(
   parameter int DIV_W  = 8,
   parameter int FRAC_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  div_int,
   input  logic [FRAC_W-1:0] div_frac,
   input  logic              nine,
   input  logic              valid,
   output logic              ready,
   input  logic [BYTE_W-1:0] byte_in,
   input  logic              bit9_in,
   output logic              line
);

   tx_state_e        state_q;
   logic [BYTE_W:0]  shift_q;
   logic [CNT_W-1:0] sent_q;
   logic [CNT_W-1:0] nbits_q;
   logic             line_q;
   logic             accept;
   logic             tick;

   assign ready  = (state_q == TX_IDLE);
   assign accept = ready && valid;
   assign line   = line_q;

   frac_bit_timer #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (state_q != TX_IDLE),
      .load     (accept),
      .half     (1'b0),
      .div_int  (div_int),
      .div_frac (div_frac),
      .tick     (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= TX_IDLE;
         shift_q <= '0;
         sent_q  <= '0;
         nbits_q <= CNT_W'(8);
         line_q  <= 1'b1;
      end else begin
         case (state_q)
            TX_IDLE: begin
               if (valid) begin
                  shift_q <= {bit9_in, byte_in};
                  nbits_q <= data_bits(nine);
                  line_q  <= 1'b0;
                  state_q <= TX_START;
               end
            end
            TX_START: begin
               if (tick) begin
                  line_q  <= shift_q[0];
                  shift_q <= shift_q >> 1;
                  sent_q  <= CNT_W'(1);
                  state_q <= TX_DATA;
               end
            end
            TX_DATA: begin
               if (tick) begin
                  if (sent_q == nbits_q) begin
                     line_q  <= 1'b1;
                     state_q <= TX_STOP;
                  end else begin
                     line_q  <= shift_q[0];
                     shift_q <= shift_q >> 1;
                     sent_q  <= sent_q + CNT_W'(1);
                  end
               end
            end
            default: begin
               if (tick) state_q <= TX_IDLE;
            end
         endcase
      end
   end

endmodule

// File: rtl/frac_uart_rx.sv
module frac_uart_rx
   import frac_uart_pkg::*;
#(
   parameter int DIV_W       = 8,
   parameter int FRAC_W      = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  div_int,
   input  logic [FRAC_W-1:0] div_frac,
   input  logic              nine,
   input  logic              line,
   output logic              valid,
   output logic [BYTE_W-1:0] byte_out,
   output logic              bit9_out,
   output logic              frame_err
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   rxs;

   generate
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[0] <= 1'b1;
               else        sync_q[0] <= line;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[s] <= 1'b1;
               else        sync_q[s] <= sync_q[s-1];
            end
         end
      end
   endgenerate

   assign rxs = sync_q[SYNC_STAGES-1];

   rx_state_e        state_q;
   logic [BYTE_W:0]  shift_q;
   logic [CNT_W-1:0] got_q;
   logic             nine_q;
   logic             valid_q;
   logic             err_q;
   logic [BYTE_W-1:0] byte_q;
   logic             bit9_q;
   logic             tick;
   logic             load;
   logic             half;

   always_comb begin
      load = 1'b0;
      half = 1'b0;
      if (state_q == RX_IDLE && !rxs) begin
         load = 1'b1;
         half = 1'b1;
      end else if (state_q == RX_START && tick && !rxs) begin
         load = 1'b1;
      end
   end

   frac_bit_timer #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (state_q != RX_IDLE),
      .load     (load),
      .half     (half),
      .div_int  (div_int),
      .div_frac (div_frac),
      .tick     (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RX_IDLE;
         shift_q <= '0;
         got_q   <= '0;
         nine_q  <= 1'b0;
         valid_q <= 1'b0;
         err_q   <= 1'b0;
         byte_q  <= '0;
         bit9_q  <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         err_q   <= 1'b0;
         case (state_q)
            RX_IDLE: begin
               if (!rxs) begin
                  nine_q  <= nine;
                  state_q <= RX_START;
               end
            end
            RX_START: begin
               if (tick) begin
                  got_q   <= '0;
                  state_q <= rxs ? RX_IDLE : RX_DATA;
               end
            end
            RX_DATA: begin
               if (tick) begin
                  shift_q <= {rxs, shift_q[BYTE_W:1]};
                  got_q   <= got_q + CNT_W'(1);
                  if (got_q == data_bits(nine_q) - CNT_W'(1)) state_q <= RX_STOP;
               end
            end
            default: begin
               if (tick) begin
                  state_q <= RX_IDLE;
                  if (rxs) begin
                     valid_q <= 1'b1;
                     if (nine_q) begin
                        byte_q <= shift_q[BYTE_W-1:0];
                        bit9_q <= shift_q[BYTE_W];
                     end else begin
                        byte_q <= shift_q[BYTE_W:1];
                        bit9_q <= 1'b0;
                     end
                  end else begin
                     err_q <= 1'b1;
                  end
               end
            end
         endcase
      end
   end

   assign valid     = valid_q;
   assign frame_err = err_q;
   assign byte_out  = byte_q;
   assign bit9_out  = bit9_q;

endmodule

// File: rtl/frac_uart.sv
module frac_uart
   import frac_uart_pkg::*;
#(
   parameter int DIV_W       = 8,
   parameter int FRAC_W      = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  cfg_div_int,
   input  logic [FRAC_W-1:0] cfg_div_frac,
   input  logic              cfg_nine,
   input  logic              tx_valid,
   output logic              tx_ready,
   input  logic [7:0]        tx_byte,
   input  logic              tx_bit9,
   output logic              tx_line,
   input  logic              rx_line,
   output logic              rx_valid,
   output logic [7:0]        rx_byte,
   output logic              rx_bit9,
   output logic              rx_frame_err
);

   generate
      if (DIV_W < 3) begin : g_bad_div
         $error("frac_uart: DIV_W must be at least 3");
      end
      if (FRAC_W < 1) begin : g_bad_frac
         $error("frac_uart: FRAC_W must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("frac_uart: SYNC_STAGES must be at least 2");
      end
   endgenerate

   frac_uart_tx #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .div_int  (cfg_div_int),
      .div_frac (cfg_div_frac),
      .nine     (cfg_nine),
      .valid    (tx_valid),
      .ready    (tx_ready),
      .byte_in  (tx_byte),
      .bit9_in  (tx_bit9),
      .line     (tx_line)
   );

   frac_uart_rx #(.DIV_W(DIV_W), .FRAC_W(FRAC_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .div_int   (cfg_div_int),
      .div_frac  (cfg_div_frac),
      .nine      (cfg_nine),
      .line      (rx_line),
      .valid     (rx_valid),
      .byte_out  (rx_byte),
      .bit9_out  (rx_bit9),
      .frame_err (rx_frame_err)
   );

endmodule

// File: rtl/frac_uart_chk.sv
module frac_uart_chk #(
   parameter int DIV_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [DIV_W-1:0] cfg_div_int,
   input logic             cfg_nine,
   input logic             tx_valid,
   input logic             tx_ready,
   input logic             tx_line,
   input logic             rx_valid,
   input logic             rx_bit9,
   input logic             rx_frame_err
);

   // R1
   idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready |-> tx_line);

   // R2
   accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready) |=> (!tx_ready && !tx_line));

   // R5
   div_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_div_int >= DIV_W'(4));

   // R6
   rx_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   // R7
   bit9_eight_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !cfg_nine) |-> !rx_bit9);

   // R8
   rx_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_valid && rx_frame_err));

   // R8
   err_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_frame_err |=> !rx_frame_err);

endmodule

bind frac_uart frac_uart_chk #(.DIV_W(DIV_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_div_int  (cfg_div_int),
   .cfg_nine     (cfg_nine),
   .tx_valid     (tx_valid),
   .tx_ready     (tx_ready),
   .tx_line      (tx_line),
   .rx_valid     (rx_valid),
   .rx_bit9      (rx_bit9),
   .rx_frame_err (rx_frame_err)
);

// File: tb/sim_frac_uart.sv
module sim_frac_uart;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] cfg_div_int = 8'd12;
   logic [2:0] cfg_div_frac = 3'd0;
   logic       cfg_nine = 1'b0;
   logic       tx_valid = 1'b0;
   logic       tx_ready;
   logic [7:0] tx_byte = 8'h00;
   logic       tx_bit9 = 1'b0;
   logic       tx_line;
   logic       rx_line = 1'b1;
   logic       rx_valid;
   logic [7:0] rx_byte;
   logic       rx_bit9;
   logic       rx_frame_err;

   int checks = 0;
   int errors = 0;
   int vcnt = 0;
   int ecnt = 0;
   logic [7:0] cap_byte;
   logic       cap_bit9;
   bit         done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   frac_uart u0 (
      .clk(clk), .rst_n(rst_n),
      .cfg_div_int(cfg_div_int), .cfg_div_frac(cfg_div_frac), .cfg_nine(cfg_nine),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_byte(tx_byte), .tx_bit9(tx_bit9),
      .tx_line(tx_line), .rx_line(rx_line), .rx_valid(rx_valid), .rx_byte(rx_byte),
      .rx_bit9(rx_bit9), .rx_frame_err(rx_frame_err)
   );

   always @(negedge clk) begin
      if (rx_valid) begin
         vcnt <= vcnt + 1;
         cap_byte <= rx_byte;
         cap_bit9 <= rx_bit9;
      end
      if (rx_frame_err) ecnt <= ecnt + 1;
   end

   function automatic int bnd(int n, int d, int f);
      return n * d + (n * f) / 8;
   endfunction

   function automatic logic exp_bit(int i, logic [7:0] b, logic b9, logic nine);
      if (i == 0) return 1'b0;
      if (i <= 8) return b[i-1];
      if (i == 9 && nine) return b9;
      return 1'b1;
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic set_cfg(int d, int f, logic nine);
      @(negedge clk);
      cfg_div_int  = 8'(d);
      cfg_div_frac = 3'(f);
      cfg_nine     = nine;
   endtask

   // R2 R3 R4 R5 R10: send one character, compare the line with the boundary formula
   task automatic run_tx(logic [7:0] b, logic b9);
      int d = int'(cfg_div_int);
      int f = int'(cfg_div_frac);
      int nb = cfg_nine ? 11 : 10;
      int mism = 0;
      int first_k = -1;
      logic [10:0] got = '0;
      logic [10:0] exp = '0;
      for (int i = 0; i < nb; i++) exp[i] = exp_bit(i, b, b9, cfg_nine);
      @(negedge clk);
      tx_byte = b; tx_bit9 = b9; tx_valid = 1'b1;
      @(negedge clk);
      tx_valid = 1'b0;
      check(!tx_ready && !tx_line, "R2", {tx_ready, tx_line}, 0);
      for (int k = 0; k <= bnd(nb, d, f); k++) begin
         if (k > 0) @(negedge clk);
         if (k < bnd(nb, d, f)) begin
            for (int i = 0; i < nb; i++) begin
               if (k >= bnd(i, d, f) && k < bnd(i + 1, d, f) && tx_line !== exp[i]) begin
                  mism++;
                  if (first_k < 0) first_k = k;
               end
               if (k == (bnd(i, d, f) + bnd(i + 1, d, f)) / 2) got[i] = tx_line;
            end
         end
         if (k == bnd(nb, d, f) - 1) check(tx_ready == 1'b0, "R10 early", tx_ready, 0);
         if (k == bnd(nb, d, f))     check(tx_ready == 1'b1, "R10 ready", tx_ready, 1);
      end
      check(mism == 0, "R5 boundary", first_k, -1);
      check(got == exp, cfg_nine ? "R4 frame" : "R3 frame", got, exp);
   endtask

   // R6 R7 R8: drive one frame into the receiver
   task automatic run_rx(logic [7:0] b, logic b9, bit stop_ok);
      int d = int'(cfg_div_int);
      int f = int'(cfg_div_frac);
      int nb = cfg_nine ? 11 : 10;
      logic bitv;
      @(negedge clk);
      vcnt = 0; ecnt = 0;
      for (int i = 0; i < nb; i++) begin
         bitv = (i == nb - 1) ? logic'(stop_ok) : exp_bit(i, b, b9, cfg_nine);
         for (int c = bnd(i, d, f); c < bnd(i + 1, d, f); c++) begin
            rx_line = bitv;
            @(negedge clk);
         end
      end
      rx_line = 1'b1;
      repeat (2 * d + 4) @(negedge clk);
      if (stop_ok) begin
         check(vcnt == 1 && ecnt == 0, "R6 pulse", vcnt, 1);
         check(cap_byte == b, "R6 byte", cap_byte, b);
         check(cap_bit9 == (cfg_nine & b9), "R7 bit9", cap_bit9, cfg_nine & b9);
      end else begin
         check(ecnt == 1 && vcnt == 0, "R8 framing", {vcnt[3:0], ecnt[3:0]}, 1);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int seed = $urandom(32'd4242);
      seed = 0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(tx_line && tx_ready && !rx_valid && !rx_frame_err, "R1 reset",
            {tx_line, tx_ready, rx_valid, rx_frame_err}, 4'b1100);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(tx_line && tx_ready, "R1 idle", {tx_line, tx_ready}, 2'b11);

      // Directed: whole divisors, 8-bit, bit9 ignored (R3)
      set_cfg(12, 0, 1'b0);
      run_tx(8'hA5, 1'b1);
      run_rx(8'hA5, 1'b1, 1'b1);
      // R4 payload tag in 9-bit mode
      set_cfg(24, 0, 1'b1);
      run_tx(8'h3C, 1'b1);
      run_rx(8'h3C, 1'b1, 1'b1);
      // R5 fractional 10.125 with control tag
      set_cfg(10, 1, 1'b1);
      run_tx(8'hF0, 1'b0);
      run_rx(8'hF0, 1'b0, 1'b1);
      // R5 largest fraction
      set_cfg(8, 7, 1'b0);
      run_tx(8'h01, 1'b0);
      run_tx(8'h80, 1'b0);
      run_rx(8'h80, 1'b0, 1'b1);
      // R8 framing error in both modes
      set_cfg(16, 3, 1'b0);
      run_rx(8'h55, 1'b0, 1'b0);
      set_cfg(16, 3, 1'b1);
      run_rx(8'hAA, 1'b1, 1'b0);
      // R9 glitch rejection, then a normal frame still received
      set_cfg(24, 0, 1'b0);
      @(negedge clk);
      vcnt = 0; ecnt = 0;
      rx_line = 1'b0;
      repeat (2) @(negedge clk);
      rx_line = 1'b1;
      repeat (3 * 24) @(negedge clk);
      check(vcnt == 0 && ecnt == 0, "R9 glitch", vcnt + ecnt, 0);
      run_rx(8'h5A, 1'b0, 1'b1);

      // Constrained random
      for (int it = 0; it < 30; it++) begin
         int d = 8 + int'($urandom % 23);
         int f = int'($urandom % 8);
         logic nine = logic'($urandom % 2);
         logic [7:0] b = 8'($urandom);
         logic b9 = logic'($urandom % 2);
         set_cfg(d, f, nine);
         run_tx(b, b9);
         run_rx(b, b9, 1'b1);
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule